// File: doc/BRIEF.md
# Amplifier Gain Calibration and Repair Manager

This block keeps an analog gain stage inside its tolerance band as the stage ages. A host pulses a start request with the address of the amplifier to service. The manager drives that address on a select bus, then reads two digital amplitude words from a shared converter through a two-position switch: first the test stimulus, then the amplifier response. From these words it forms a scaled gain estimate and compares it with a stored reference window.

Inside the window nothing changes. Outside it, a small table of step sizes, indexed by the size of the error, moves a 3-bit bias-trim code, and a new measurement pass confirms the result. Raising the code adds bias current and lowers the gain. An error too large for trim, a code that would leave its range, or too many passes moves the path onto a duplicate amplifier, which is then verified. If the duplicate also fails, the trim is parked at a safe code and a sticky halt is raised. A stimulus word that is too small is reported as a measurement fault and is never used as a divisor.

Top module: `gain_cal_mgr`

## Requirements
- R1: Out of reset busy_o=0, done_o=0, trim_o=3, spare_o=0, halt_o=0, fault_o=0.
- R2: start_i is taken only when idle and not halted. busy_o then stays high until done_o, which is high for exactly one cycle. A start_i during busy has no effect on timing, result or sel_o.
- R3: sel_o holds the address latched at start for the whole run. sel_vld_o is high for one cycle at the start of each measurement pass.
- R4: Each pass samples meas_i with meas_sw_o=0 (stimulus) in the cycle after sel_vld_o, then with meas_sw_o=1 (response) in the next cycle.
- R5: The gain estimate is response*FB_MUL/stimulus (FB_MUL=16). If |estimate-REF| <= TOL (REF=160, TOL=4), trim_o, spare_o and fault_o are left unchanged and done_o follows.
- R6: For TOL < |error| <= MAX_DEV (48), the step is taken from a table indexed by min(|error|>>3, 3), with steps {1,1,2,3}. An estimate above REF adds the step to trim_o and one below subtracts it.
- R7: Every trim or spare change is followed by a new measurement pass. A pass takes 5 cycles from the start edge (or from the prior decision) to its decision.
- R8: The path moves to the spare (spare_o=1, trim_o reset to 3, pass count cleared) when |error| > MAX_DEV, when the step would take trim_o outside 0..7, or when MAX_PASSES (4) passes are used up.
- R9: If a correction is needed while the spare is already in use, trim_o goes to 0, halt_o=1 and fault_o=2. All of these hold until reset, and later starts are ignored.
- R10: A stimulus word below MIN_IN (8) ends the run 4 cycles after start with fault_o=1 and no change to trim_o or spare_o. A word of exactly 8 is used normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Host start request |
| amp_sel_i | input | 3 | Address of the amplifier to service |
| meas_i | input | 12 | Converted amplitude word |
| sel_o | output | 3 | Select bus address |
| sel_vld_o | output | 1 | Select strobe, one cycle per pass |
| meas_sw_o | output | 1 | Measurement switch: 0 stimulus, 1 response |
| trim_o | output | 3 | Bias-trim code |
| spare_o | output | 1 | Signal path rerouted to the duplicate amplifier |
| halt_o | output | 1 | Unrepairable fault, output forced safe |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| fault_o | output | 2 | 0 none, 1 measurement error, 2 unrepairable |

## Verification
A run's result is due a fixed number of edges after the start edge: 5 per measurement pass, or 4 when the stimulus is rejected. Each bench vector therefore carries its expected edge count, and the bench counts edges up to done_o and compares the count. All outputs are sampled on the falling edge of the cycle that shows done_o, and done_o and busy_o are sampled again one cycle later. The switch order is checked on the first and second falling edges after each select strobe.

// File: rtl/gcm_pkg.sv
package gcm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_SEL, ST_MIN, ST_MOUT, ST_CALC, ST_DEC, ST_DONE
  } gcm_st_e;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_MEAS = 2'd1,
    FLT_DEAD = 2'd2
  } gcm_flt_e;
endpackage

// File: rtl/gcm_gain_est.sv
module gcm_gain_est #(
  parameter int DW     = 12,
  parameter int GW     = 12,
  parameter int FB_MUL = 16,
  parameter int MIN_IN = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cap_in_i,
  input  logic          cap_out_i,
  input  logic          calc_i,
  input  logic [DW-1:0] meas_i,
  output logic          in_low_o,
  output logic [GW-1:0] gain_o
);
  localparam int FBW  = $clog2(FB_MUL + 1);
  localparam int PW   = DW + FBW;
  localparam int GMAX = (1 << GW) - 1;

  logic [DW-1:0] in_q, out_q;
  logic [PW-1:0] prod, dvsr, quo;
  logic [GW-1:0] gain_q, sat;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_q  <= '0;
      out_q <= '0;
    end else begin
      if (cap_in_i)  in_q  <= meas_i;
      if (cap_out_i) out_q <= meas_i;
    end
  end

  assign in_low_o = in_q < DW'(MIN_IN);

  always_comb begin
    prod = PW'(out_q) * PW'(FB_MUL);
    dvsr = (in_q == '0) ? PW'(1) : PW'(in_q);
    quo  = prod / dvsr;
    sat  = (quo > PW'(GMAX)) ? GW'(GMAX) : quo[GW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     gain_q <= '0;
    else if (calc_i) gain_q <= sat;
  end

  assign gain_o = gain_q;

  // R10: an undersized stimulus word never reaches the estimate unflagged
  a_r10_low_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_in_i && meas_i < DW'(MIN_IN)) |=> in_low_o);
endmodule

// File: rtl/gcm_trim_lut.sv
module gcm_trim_lut #(
  parameter int GW        = 12,
  parameter int CW        = 3,
  parameter int REF       = 160,
  parameter int TOL       = 4,
  parameter int MAX_DEV   = 48,
  parameter int IDX_SHIFT = 3,
  parameter int LUT_N     = 4,
  parameter logic [LUT_N*CW-1:0] STEP_TABLE = {3'd3, 3'd2, 3'd1, 3'd1}
) (
  input  logic [GW-1:0] gain_i,
  input  logic [CW-1:0] code_i,
  output logic          in_tol_o,
  output logic          too_far_o,
  output logic          exhaust_o,
  output logic [CW-1:0] code_nxt_o
);
  localparam int IW = (LUT_N > 1) ? $clog2(LUT_N) : 1;

  logic signed [GW:0] dev;
  logic [GW:0]        mag, idx_raw;
  logic [IW-1:0]      idx;
  logic [CW-1:0]      step;
  logic [CW:0]        up;

  always_comb begin
    dev     = $signed({1'b0, gain_i}) - $signed((GW+1)'(REF));
    mag     = dev[GW] ? (GW+1)'(-dev) : (GW+1)'(dev);
    idx_raw = mag >> IDX_SHIFT;
    idx     = (idx_raw >= (GW+1)'(LUT_N)) ? IW'(LUT_N - 1) : idx_raw[IW-1:0];
  end

  always_comb begin
    step = '0;
    for (int k = 0; k < LUT_N; k++)
      if (idx == IW'(k)) step = STEP_TABLE[k*CW +: CW];
  end

  assign in_tol_o  = mag <= (GW+1)'(TOL);
  assign too_far_o = mag > (GW+1)'(MAX_DEV);
  assign up        = {1'b0, code_i} + {1'b0, step};

  // gain high -> more bias current (code up); gain low -> code down
  always_comb begin
    if (!dev[GW]) begin
      exhaust_o  = up[CW];
      code_nxt_o = up[CW-1:0];
    end else begin
      exhaust_o  = step > code_i;
      code_nxt_o = code_i - step;
    end
  end
endmodule

// File: rtl/gcm_seq.sv
module gcm_seq
  import gcm_pkg::*;
#(
  parameter int AW         = 3,
  parameter int CW         = 3,
  parameter int MAX_PASSES = 4,
  parameter int RESET_CODE = 3,
  parameter int SAFE_CODE  = 0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] amp_sel_i,
  input  logic          in_low_i,
  input  logic          in_tol_i,
  input  logic          too_far_i,
  input  logic          exhaust_i,
  input  logic [CW-1:0] code_nxt_i,
  output logic          cap_in_o,
  output logic          cap_out_o,
  output logic          calc_o,
  output logic [AW-1:0] sel_o,
  output logic          sel_vld_o,
  output logic          meas_sw_o,
  output logic [CW-1:0] trim_o,
  output logic          spare_o,
  output logic          halt_o,
  output logic          busy_o,
  output logic          done_o,
  output logic [1:0]    fault_o
);
  localparam int PCW = $clog2(MAX_PASSES + 1);

  gcm_st_e       st_q;
  gcm_flt_e      flt_q;
  logic [AW-1:0] sel_q;
  logic [CW-1:0] code_q;
  logic [PCW-1:0] pass_q;
  logic          spare_q, halt_q;
  logic          trim_ok;

  assign trim_ok = !too_far_i && !exhaust_i && (pass_q < PCW'(MAX_PASSES));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      flt_q   <= FLT_NONE;
      sel_q   <= '0;
      code_q  <= CW'(RESET_CODE);
      pass_q  <= '0;
      spare_q <= 1'b0;
      halt_q  <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i && !halt_q) begin
          sel_q  <= amp_sel_i;
          flt_q  <= FLT_NONE;
          pass_q <= '0;
          st_q   <= ST_SEL;
        end
        ST_SEL:  st_q <= ST_MIN;
        ST_MIN:  st_q <= ST_MOUT;
        ST_MOUT: st_q <= ST_CALC;
        ST_CALC: begin
          pass_q <= pass_q + PCW'(1);
          if (in_low_i) begin
            flt_q <= FLT_MEAS;
            st_q  <= ST_DONE;
          end else begin
            st_q  <= ST_DEC;
          end
        end
        ST_DEC: begin
          if (in_tol_i) begin
            st_q <= ST_DONE;
          end else if (trim_ok) begin
            code_q <= code_nxt_i;
            st_q   <= ST_SEL;
          end else if (!spare_q) begin
            spare_q <= 1'b1;
            code_q  <= CW'(RESET_CODE);
            pass_q  <= '0;
            st_q    <= ST_SEL;
          end else begin
            halt_q <= 1'b1;
            code_q <= CW'(SAFE_CODE);
            flt_q  <= FLT_DEAD;
            st_q   <= ST_DONE;
          end
        end
        ST_DONE: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign cap_in_o  = st_q == ST_MIN;
  assign cap_out_o = st_q == ST_MOUT;
  assign calc_o    = st_q == ST_CALC;
  assign sel_o     = sel_q;
  assign sel_vld_o = st_q == ST_SEL;
  assign meas_sw_o = st_q == ST_MOUT;
  assign trim_o    = code_q;
  assign spare_o   = spare_q;
  assign halt_o    = halt_q;
  assign busy_o    = st_q != ST_IDLE;
  assign done_o    = st_q == ST_DONE;
  assign fault_o   = flt_q;

  a_r2_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r2_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> !busy_o);
  a_r3_sel_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(sel_o));
  a_r4_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    meas_sw_o |-> $past(cap_in_o));
  a_r7_reverify: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(trim_o) && !halt_o) |-> sel_vld_o);
  a_r8_spare_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spare_o |=> spare_o);
  a_r8_pass_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pass_q <= PCW'(MAX_PASSES));
  a_r9_halt_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |=> (halt_o && trim_o == CW'(SAFE_CODE) && fault_o == 2'd2));
endmodule

// File: rtl/gain_cal_mgr.sv
module gain_cal_mgr #(
  parameter int AW         = 3,
  parameter int DW         = 12,
  parameter int GW         = 12,
  parameter int CW         = 3,
  parameter int FB_MUL     = 16,
  parameter int MIN_IN     = 8,
  parameter int REF        = 160,
  parameter int TOL        = 4,
  parameter int MAX_DEV    = 48,
  parameter int MAX_PASSES = 4,
  parameter int RESET_CODE = 3,
  parameter int SAFE_CODE  = 0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] amp_sel_i,
  input  logic [DW-1:0] meas_i,
  output logic [AW-1:0] sel_o,
  output logic          sel_vld_o,
  output logic          meas_sw_o,
  output logic [CW-1:0] trim_o,
  output logic          spare_o,
  output logic          halt_o,
  output logic          busy_o,
  output logic          done_o,
  output logic [1:0]    fault_o
);
  logic          cap_in, cap_out, calc, in_low;
  logic          in_tol, too_far, exhaust;
  logic [GW-1:0] gain;
  logic [CW-1:0] code_nxt;

  gcm_gain_est #(
    .DW(DW), .GW(GW), .FB_MUL(FB_MUL), .MIN_IN(MIN_IN)
  ) u_est (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .cap_in_i(cap_in), .cap_out_i(cap_out), .calc_i(calc),
    .meas_i(meas_i), .in_low_o(in_low), .gain_o(gain)
  );

  gcm_trim_lut #(
    .GW(GW), .CW(CW), .REF(REF), .TOL(TOL), .MAX_DEV(MAX_DEV)
  ) u_lut (
    .gain_i(gain), .code_i(trim_o),
    .in_tol_o(in_tol), .too_far_o(too_far),
    .exhaust_o(exhaust), .code_nxt_o(code_nxt)
  );

  gcm_seq #(
    .AW(AW), .CW(CW), .MAX_PASSES(MAX_PASSES),
    .RESET_CODE(RESET_CODE), .SAFE_CODE(SAFE_CODE)
  ) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .start_i(start_i), .amp_sel_i(amp_sel_i),
    .in_low_i(in_low), .in_tol_i(in_tol), .too_far_i(too_far),
    .exhaust_i(exhaust), .code_nxt_i(code_nxt),
    .cap_in_o(cap_in), .cap_out_o(cap_out), .calc_o(calc),
    .sel_o(sel_o), .sel_vld_o(sel_vld_o), .meas_sw_o(meas_sw_o),
    .trim_o(trim_o), .spare_o(spare_o), .halt_o(halt_o),
    .busy_o(busy_o), .done_o(done_o), .fault_o(fault_o)
  );
endmodule

// File: tb/gain_cal_mgr_bench.sv
module gain_cal_mgr_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  amp_sel = '0;
  logic [11:0] meas;
  logic [2:0]  sel, trim;
  logic        sel_vld, sw, spare, halt, busy, done;
  logic [1:0]  fault;

  int checks = 0;
  int fails  = 0;
  int in_amp = 64, pbase = 184, sbase = 184;

  always #2 clk = ~clk;

  gain_cal_mgr u_gain_cal_mgr (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .amp_sel_i(amp_sel),
    .meas_i(meas), .sel_o(sel), .sel_vld_o(sel_vld), .meas_sw_o(sw),
    .trim_o(trim), .spare_o(spare), .halt_o(halt), .busy_o(busy),
    .done_o(done), .fault_o(fault)
  );

  // amplifier model: gain in 1/16 units, each trim step lowers it by 8
  always_comb begin
    int g;
    g = (spare ? sbase : pbase) - 8 * int'(trim);
    meas = sw ? 12'((in_amp * g) / 16) : 12'(in_amp);
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // {stimulus, primary base, spare base, latency, trim, spare, halt, fault}
  localparam int NV = 10;
  localparam logic [50:0] VECS [NV] = '{
    {12'd64, 12'd184, 12'd184, 8'd5,  3'd3, 1'b0, 1'b0, 2'd0}, // R5 in window
    {12'd64, 12'd188, 12'd184, 8'd5,  3'd3, 1'b0, 1'b0, 2'd0}, // R5 error = TOL
    {12'd64, 12'd200, 12'd184, 8'd10, 3'd5, 1'b0, 1'b0, 2'd0}, // R6 high, step 2
    {12'd64, 12'd176, 12'd184, 8'd10, 3'd2, 1'b0, 1'b0, 2'd0}, // R6 low, step 1
    {12'd64, 12'd250, 12'd184, 8'd10, 3'd3, 1'b1, 1'b0, 2'd0}, // R8 too far
    {12'd64, 12'd150, 12'd184, 8'd15, 3'd3, 1'b1, 1'b0, 2'd0}, // R8 underflow
    {12'd64, 12'd232, 12'd184, 8'd15, 3'd3, 1'b1, 1'b0, 2'd0}, // R8 error = MAX_DEV
    {12'd64, 12'd250, 12'd250, 8'd10, 3'd0, 1'b1, 1'b1, 2'd2}, // R9 halt
    {12'd2,  12'd184, 12'd184, 8'd4,  3'd3, 1'b0, 1'b0, 2'd1}, // R10 low stim
    {12'd8,  12'd184, 12'd184, 8'd5,  3'd3, 1'b0, 1'b0, 2'd0}  // R10 boundary
  };

  function automatic string tag(input int i);
    case (i)
      0, 1:    return "R5";
      2, 3:    return "R6";
      4, 5, 6: return "R8";
      7:       return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    start = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    do_reset();
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 trim", trim, 3);
    chk("R1 spare", spare, 0);
    chk("R1 halt", halt, 0);
    chk("R1 fault", fault, 0);

    for (int i = 0; i < NV; i++) begin
      logic [50:0] v;
      logic [2:0]  orig;
      int lat, k;
      v = VECS[i];
      in_amp = int'(v[50:39]);
      pbase  = int'(v[38:27]);
      sbase  = int'(v[26:15]);
      do_reset();
      orig    = 3'(i + 1);
      amp_sel = orig;
      start   = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      lat = 0;
      k   = -1;
      while (!done && lat < 100) begin
        if (sel_vld) k = 0;
        @(posedge clk);
        lat++;
        @(negedge clk);
        if (k >= 0) begin
          k++;
          if (k == 1) chk("R4 stimulus first", sw, 0);
          if (k == 2) begin chk("R4 response second", sw, 1); k = -1; end
        end
        // start during busy must be ignored (R2)
        if (lat == 2) begin start = 1'b1; amp_sel = ~orig; end
        else start = 1'b0;
      end
      chk({tag(i), " R7 latency"}, lat, int'(v[14:7]));
      chk({tag(i), " trim"}, trim, int'(v[6:4]));
      chk({tag(i), " spare"}, spare, int'(v[3]));
      chk({tag(i), " halt"}, halt, int'(v[2]));
      chk({tag(i), " fault"}, fault, int'(v[1:0]));
      chk("R3 sel held", sel, orig);
      chk("R2 busy at done", busy, 1);
      @(posedge clk);
      @(negedge clk);
      chk("R2 done one cycle", done, 0);
      chk("R2 idle after done", busy, 0);
      if (v[2]) begin
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        chk("R9 start ignored", busy, 0);
        chk("R9 halt kept", halt, 1);
        chk("R9 safe trim", trim, 0);
      end
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule